// File: doc/BRIEF.md
# Programmable Asynchronous Memory Bus Sequencer

This block turns single read and write requests from an internal host port into timed cycles on an external asynchronous memory bus. The bus has 9 address lines (a 1 KiB space), a 16-bit data path split into input, output and output-enable, active-low output and write strobes, and six active-low chip-select lines. Every chip select has its own 32-bit timing word that sets how long reads and writes last, how long a write is held after the strobe, how long the bus rests after a read, and how much extra latency the first access to a new page or burst region costs.

The host presents a request with an address, a chip-select index, a direction and write data. The request is taken in any cycle where `host_req` and `host_ready` are both high. `host_ready` then stays low until the whole access has finished, including any recovery and write hold. Read data comes back with a one-cycle `host_rvalid` pulse. The per-chip-select timing words are loaded through a small indexed register port.

Top module: `ambus_seq`

## Requirements
- R1: After reset, `host_ready` is 1, all `mem_cs_n` bits, `mem_oe_n` and `mem_we_n` are 1, `mem_dq_oe` is 0, and every timing word reads as zero (all fields 0).
- R2: A read drives the selected `mem_cs_n` bit and `mem_oe_n` low, with `mem_addr` equal to the request address, for read_wait+1 cycles (plus read_delta on a first access). `host_rdata` holds the value on `mem_dq_i` in the last of those cycles, and `host_rvalid` is high for exactly the one cycle after them.
- R3: A write drives the selected `mem_cs_n` bit and `mem_we_n` low for write_wait+1 cycles (plus write_delta on a first access). `mem_dq_oe` is high and `mem_dq_o` equals the write data throughout. `mem_dq_oe` is never high while `mem_oe_n` is low.
- R4: After the write strobe, the chip select stays low with `mem_we_n` high and the write data still driven for hold+1 cycles.
- R5: The page of an access is address bits [8:4]. An access is a first access when it is the first one since reset, or when its chip select or page differs from those of the previous access. Only a first access gets the delta latency.
- R6: When the previous access was a read and the new one targets a different chip select or is a write, max(recovery,1) cycles with every chip select, `mem_oe_n` and `mem_we_n` high come before the new access.
- R7: No recovery cycles are inserted after a write, or for a read that follows a read on the same chip select.
- R8: `host_ready` goes low in the cycle after a request is accepted and stays low for exactly recovery + access + hold cycles. It then returns high.
- R9: Timing word layout: [3:0] read_wait, [7:4] write_wait, [11:8] hold, [15:12] recovery, [23:16] read_delta, [31:24] write_delta. A write through the config port with index `cfg_cs` changes only that chip select's timing.
- R10: At most one `mem_cs_n` bit is low at any time, and `mem_oe_n` and `mem_we_n` are never low together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_we | input | 1 | Timing word write strobe |
| cfg_cs | input | 3 | Chip select whose timing word is written |
| cfg_data | input | 32 | Timing word value |
| host_req | input | 1 | Access request |
| host_we | input | 1 | 1 = write, 0 = read |
| host_cs | input | 3 | Target chip select, 0 to 5 |
| host_addr | input | 9 | Access address |
| host_wdata | input | 16 | Write data |
| host_ready | output | 1 | Ready to accept a request |
| host_rdata | output | 16 | Read data |
| host_rvalid | output | 1 | Read data valid pulse |
| mem_addr | output | 9 | External address |
| mem_dq_o | output | 16 | External data out |
| mem_dq_oe | output | 1 | External data output enable |
| mem_dq_i | input | 16 | External data in |
| mem_oe_n | output | 1 | Output enable, active low |
| mem_we_n | output | 1 | Write enable, active low |
| mem_cs_n | output | 6 | Chip selects, active low |

## Verification
The hardest situation to reach is one where recovery and first-access latency apply to the same access at once. Getting there needs a read followed by a write or a change of chip select, with the page tracker also seeing a new region. The stimulus sweeps eight timing configurations across all six chip selects. In each sweep it walks an access pattern that mixes chip selects, pages and directions, so every combination of recovery and first access comes up with several field values. A final stage sets the largest wait, delta and recovery values to check the counter limits.

// File: rtl/ambus_pkg.sv
// Package: shared constants and the per-chip-select timing word layout.
// Assumes the word is written as one 32-bit value; field order is fixed by R9.
package ambus_pkg;
    localparam int WAIT_W  = 4;
    localparam int DELTA_W = 8;
    localparam int CNT_W   = DELTA_W + 1;

    typedef struct packed {
        logic [DELTA_W-1:0] wr_delta;
        logic [DELTA_W-1:0] rd_delta;
        logic [WAIT_W-1:0]  recov;
        logic [WAIT_W-1:0]  hold;
        logic [WAIT_W-1:0]  wr_wait;
        logic [WAIT_W-1:0]  rd_wait;
    } cs_timing_t;

    localparam int TIM_W = $bits(cs_timing_t);

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_REC  = 2'd1,
        ST_ACC  = 2'd2,
        ST_HOLD = 2'd3
    } seq_state_t;
endpackage

// File: rtl/ambus_timing_regs.sv
// Module: bank of per-chip-select timing words.
// One word per chip select, written by index; writes to an index of
// NUM_CS or above are dropped. The read port is combinational.
module ambus_timing_regs
    import ambus_pkg::*;
#(
    parameter int NUM_CS = 6,
    parameter int IDX_W  = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [IDX_W-1:0] wr_idx,
    input  cs_timing_t       wr_data,
    input  logic [IDX_W-1:0] rd_idx,
    output cs_timing_t       rd_data
);
    cs_timing_t regs [NUM_CS];

    for (genvar g = 0; g < NUM_CS; g++) begin : g_word
        // Purpose: hold the timing word of chip select g.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                regs[g] <= '0;
            end else if (wr_en && (wr_idx == IDX_W'(g))) begin
                regs[g] <= wr_data;
            end
        end
    end

    // Purpose: select the timing word of the requested chip select.
    always_comb begin
        rd_data = '0;
        for (int i = 0; i < NUM_CS; i++) begin
            if (rd_idx == IDX_W'(i)) rd_data = regs[i];
        end
    end
endmodule

// File: rtl/ambus_history.sv
// Module: tracks the previous access to decide on recovery and first-access latency.
// Assumes upd pulses once per accepted request, with the request's fields valid.
module ambus_history #(
    parameter int IDX_W  = 3,
    parameter int PAGE_W = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              upd,
    input  logic              new_we,
    input  logic [IDX_W-1:0]  new_cs,
    input  logic [PAGE_W-1:0] new_page,
    output logic              need_rec,
    output logic              is_first
);
    logic              seen;
    logic              last_rd;
    logic [IDX_W-1:0]  last_cs;
    logic [PAGE_W-1:0] last_page;

    // Purpose: remember the direction, chip select and page of the last access.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            seen      <= 1'b0;
            last_rd   <= 1'b0;
            last_cs   <= '0;
            last_page <= '0;
        end else if (upd) begin
            seen      <= 1'b1;
            last_rd   <= !new_we;
            last_cs   <= new_cs;
            last_page <= new_page;
        end
    end

    // Purpose: classify the incoming request against that history.
    always_comb begin
        need_rec = last_rd && ((new_cs != last_cs) || new_we);
        is_first = !seen || (new_cs != last_cs) || (new_page != last_page);
    end

    // R7: no recovery is requested right after reset, before any read.
    p_no_rec_before_read_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !seen |-> !need_rec);
endmodule

// File: rtl/ambus_seq_ctrl.sv
// Module: access sequencer with a shared down-counter and registered bus outputs.
// Assumes the timing word and history flags are valid in the accept cycle.
// Bus outputs are decoded from the next state, so they change on the same
// edge as the state register.
module ambus_seq_ctrl
    import ambus_pkg::*;
#(
    parameter int NUM_CS = 6,
    parameter int IDX_W  = 3,
    parameter int ADDR_W = 9,
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req,
    input  logic              req_we,
    input  logic [IDX_W-1:0]  req_cs,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DATA_W-1:0] req_wdata,
    input  cs_timing_t        tim,
    input  logic              need_rec,
    input  logic              is_first,
    input  logic [DATA_W-1:0] mem_dq_i,
    output logic              ready,
    output logic              accept,
    output logic [DATA_W-1:0] rdata,
    output logic              rvalid,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [DATA_W-1:0] mem_dq_o,
    output logic              mem_dq_oe,
    output logic              mem_oe_n,
    output logic              mem_we_n,
    output logic [NUM_CS-1:0] mem_cs_n
);
    seq_state_t        state, state_nxt;
    logic [CNT_W-1:0]  cnt, cnt_nxt;
    logic [CNT_W-1:0]  acc_len, acc_len_nxt;
    logic [CNT_W-1:0]  hold_len, hold_len_nxt;
    logic              r_we, r_we_nxt;
    logic [IDX_W-1:0]  r_cs, r_cs_nxt;
    logic [ADDR_W-1:0] r_addr, r_addr_nxt;
    logic [DATA_W-1:0] r_wdata, r_wdata_nxt;
    logic [CNT_W-1:0]  wait_ext, delta_ext, rec_m1;
    logic              last_acc;

    logic [ADDR_W-1:0] addr_d;
    logic [DATA_W-1:0] dq_d;
    logic              dq_oe_d, oe_n_d, we_n_d;
    logic [NUM_CS-1:0] cs_n_d;

    assign ready    = (state == ST_IDLE);
    assign accept   = req && ready;
    assign last_acc = (state == ST_ACC) && (cnt == '0);

    // Purpose: derive access, recovery and hold lengths (minus one) from the timing word.
    always_comb begin
        wait_ext  = req_we ? CNT_W'(tim.wr_wait) : CNT_W'(tim.rd_wait);
        delta_ext = '0;
        if (is_first) delta_ext = req_we ? CNT_W'(tim.wr_delta) : CNT_W'(tim.rd_delta);
        rec_m1    = (tim.recov == '0) ? '0 : CNT_W'(tim.recov - 1'b1);
    end

    // Purpose: next-state, counter and request-capture logic.
    always_comb begin
        state_nxt    = state;
        cnt_nxt      = cnt;
        acc_len_nxt  = acc_len;
        hold_len_nxt = hold_len;
        r_we_nxt     = r_we;
        r_cs_nxt     = r_cs;
        r_addr_nxt   = r_addr;
        r_wdata_nxt  = r_wdata;
        unique case (state)
            ST_IDLE: begin
                if (accept) begin
                    r_we_nxt     = req_we;
                    r_cs_nxt     = req_cs;
                    r_addr_nxt   = req_addr;
                    r_wdata_nxt  = req_wdata;
                    acc_len_nxt  = wait_ext + delta_ext;
                    hold_len_nxt = CNT_W'(tim.hold);
                    if (need_rec) begin
                        state_nxt = ST_REC;
                        cnt_nxt   = rec_m1;
                    end else begin
                        state_nxt = ST_ACC;
                        cnt_nxt   = wait_ext + delta_ext;
                    end
                end
            end
            ST_REC: begin
                if (cnt == '0) begin
                    state_nxt = ST_ACC;
                    cnt_nxt   = acc_len;
                end else begin
                    cnt_nxt = cnt - 1'b1;
                end
            end
            ST_ACC: begin
                if (cnt == '0) begin
                    if (r_we) begin
                        state_nxt = ST_HOLD;
                        cnt_nxt   = hold_len;
                    end else begin
                        state_nxt = ST_IDLE;
                    end
                end else begin
                    cnt_nxt = cnt - 1'b1;
                end
            end
            ST_HOLD: begin
                if (cnt == '0) state_nxt = ST_IDLE;
                else           cnt_nxt   = cnt - 1'b1;
            end
            default: state_nxt = ST_IDLE;
        endcase
    end

    // Purpose: decode the bus pin values for the coming cycle.
    always_comb begin
        addr_d  = '0;
        dq_d    = '0;
        dq_oe_d = 1'b0;
        oe_n_d  = 1'b1;
        we_n_d  = 1'b1;
        cs_n_d  = '1;
        if (state_nxt == ST_ACC || state_nxt == ST_HOLD) begin
            addr_d = r_addr_nxt;
            for (int i = 0; i < NUM_CS; i++) begin
                if (r_cs_nxt == IDX_W'(i)) cs_n_d[i] = 1'b0;
            end
            if (r_we_nxt) begin
                dq_d    = r_wdata_nxt;
                dq_oe_d = 1'b1;
                we_n_d  = (state_nxt != ST_ACC);
            end else begin
                oe_n_d  = (state_nxt != ST_ACC);
            end
        end
    end

    // Purpose: state, request and counter registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state    <= ST_IDLE;
            cnt      <= '0;
            acc_len  <= '0;
            hold_len <= '0;
            r_we     <= 1'b0;
            r_cs     <= '0;
            r_addr   <= '0;
            r_wdata  <= '0;
        end else begin
            state    <= state_nxt;
            cnt      <= cnt_nxt;
            acc_len  <= acc_len_nxt;
            hold_len <= hold_len_nxt;
            r_we     <= r_we_nxt;
            r_cs     <= r_cs_nxt;
            r_addr   <= r_addr_nxt;
            r_wdata  <= r_wdata_nxt;
        end
    end

    // Purpose: registered bus outputs.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mem_addr  <= '0;
            mem_dq_o  <= '0;
            mem_dq_oe <= 1'b0;
            mem_oe_n  <= 1'b1;
            mem_we_n  <= 1'b1;
            mem_cs_n  <= '1;
        end else begin
            mem_addr  <= addr_d;
            mem_dq_o  <= dq_d;
            mem_dq_oe <= dq_oe_d;
            mem_oe_n  <= oe_n_d;
            mem_we_n  <= we_n_d;
            mem_cs_n  <= cs_n_d;
        end
    end

    // Purpose: capture read data on the last strobe cycle and flag it.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rdata  <= '0;
            rvalid <= 1'b0;
        end else begin
            rvalid <= last_acc && !r_we;
            if (last_acc && !r_we) rdata <= mem_dq_i;
        end
    end

    p_one_cs_r10: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(~mem_cs_n));
    p_no_oe_we_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !(!mem_oe_n && !mem_we_n));
    p_no_drive_on_read_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !mem_oe_n |-> !mem_dq_oe);
    p_busy_after_accept_r8: assert property (@(posedge clk) disable iff (!rst_n)
        accept |=> !ready);
    p_rec_bus_idle_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_REC) |-> (&mem_cs_n && mem_oe_n && mem_we_n));
    p_rvalid_after_oe_r2: assert property (@(posedge clk) disable iff (!rst_n)
        rvalid |-> $past(!mem_oe_n));
    p_hold_drives_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_HOLD) |-> (mem_we_n && mem_dq_oe && !(&mem_cs_n)));
endmodule

// File: rtl/ambus_seq.sv
// Module: top of the asynchronous memory bus sequencer.
// Assumes host_cs is below NUM_CS; ties the timing bank, access history
// and sequencer together.
module ambus_seq
    import ambus_pkg::*;
#(
    parameter int NUM_CS   = 6,
    parameter int ADDR_W   = 9,
    parameter int DATA_W   = 16,
    parameter int PAGE_LSB = 4,
    localparam int IDX_W   = $clog2(NUM_CS),
    localparam int PAGE_W  = ADDR_W - PAGE_LSB
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_we,
    input  logic [IDX_W-1:0]  cfg_cs,
    input  logic [TIM_W-1:0]  cfg_data,
    input  logic              host_req,
    input  logic              host_we,
    input  logic [IDX_W-1:0]  host_cs,
    input  logic [ADDR_W-1:0] host_addr,
    input  logic [DATA_W-1:0] host_wdata,
    output logic              host_ready,
    output logic [DATA_W-1:0] host_rdata,
    output logic              host_rvalid,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [DATA_W-1:0] mem_dq_o,
    output logic              mem_dq_oe,
    input  logic [DATA_W-1:0] mem_dq_i,
    output logic              mem_oe_n,
    output logic              mem_we_n,
    output logic [NUM_CS-1:0] mem_cs_n
);
    cs_timing_t tim;
    logic       accept, need_rec, is_first;

    ambus_timing_regs #(.NUM_CS(NUM_CS), .IDX_W(IDX_W)) u_regs (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (cfg_we),
        .wr_idx  (cfg_cs),
        .wr_data (cs_timing_t'(cfg_data)),
        .rd_idx  (host_cs),
        .rd_data (tim)
    );

    ambus_history #(.IDX_W(IDX_W), .PAGE_W(PAGE_W)) u_hist (
        .clk      (clk),
        .rst_n    (rst_n),
        .upd      (accept),
        .new_we   (host_we),
        .new_cs   (host_cs),
        .new_page (host_addr[ADDR_W-1:PAGE_LSB]),
        .need_rec (need_rec),
        .is_first (is_first)
    );

    ambus_seq_ctrl #(.NUM_CS(NUM_CS), .IDX_W(IDX_W), .ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .req       (host_req),
        .req_we    (host_we),
        .req_cs    (host_cs),
        .req_addr  (host_addr),
        .req_wdata (host_wdata),
        .tim       (tim),
        .need_rec  (need_rec),
        .is_first  (is_first),
        .mem_dq_i  (mem_dq_i),
        .ready     (host_ready),
        .accept    (accept),
        .rdata     (host_rdata),
        .rvalid    (host_rvalid),
        .mem_addr  (mem_addr),
        .mem_dq_o  (mem_dq_o),
        .mem_dq_oe (mem_dq_oe),
        .mem_oe_n  (mem_oe_n),
        .mem_we_n  (mem_we_n),
        .mem_cs_n  (mem_cs_n)
    );
endmodule

// File: tb/sim_ambus_seq.sv
// Bench: sweeps timing configurations and access patterns, predicting every
// cycle count from the requirements with its own model of the access history.
module sim_ambus_seq;
    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG   = 150000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_we = 1'b0;
    logic [2:0]  cfg_cs = '0;
    logic [31:0] cfg_data = '0;
    logic        host_req = 1'b0;
    logic        host_we = 1'b0;
    logic [2:0]  host_cs = '0;
    logic [8:0]  host_addr = '0;
    logic [15:0] host_wdata = '0;
    logic        host_ready, host_rvalid, mem_dq_oe, mem_oe_n, mem_we_n;
    logic [15:0] host_rdata, mem_dq_o, mem_dq_i;
    logic [8:0]  mem_addr;
    logic [5:0]  mem_cs_n;

    int checks = 0;
    int errors = 0;
    int cyc = 0;
    int cfgs [6];
    bit m_seen = 0, m_lastrd = 0;
    int m_cs = 0, m_page = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    // Memory model: returns a pattern tied to the address while output enable is low.
    assign mem_dq_i = !mem_oe_n ? {7'h35, mem_addr} : 16'hDEAD;

    ambus_seq u0 (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_cs(cfg_cs), .cfg_data(cfg_data),
        .host_req(host_req), .host_we(host_we), .host_cs(host_cs), .host_addr(host_addr),
        .host_wdata(host_wdata), .host_ready(host_ready), .host_rdata(host_rdata),
        .host_rvalid(host_rvalid), .mem_addr(mem_addr), .mem_dq_o(mem_dq_o),
        .mem_dq_oe(mem_dq_oe), .mem_dq_i(mem_dq_i), .mem_oe_n(mem_oe_n),
        .mem_we_n(mem_we_n), .mem_cs_n(mem_cs_n)
    );

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    function automatic int pack(int rdw, int wrw, int hd, int rc, int rdd, int wrd);
        return (wrd << 24) | (rdd << 16) | (rc << 12) | (hd << 8) | (wrw << 4) | rdw;
    endfunction

    task automatic write_cfg(input int cs, input int val);
        @(negedge clk);
        cfg_we = 1'b1; cfg_cs = 3'(cs); cfg_data = 32'(val);
        @(negedge clk);
        cfg_we = 1'b0;
        cfgs[cs] = val;
    endtask

    // One access; predicts recovery, strobe, hold and total busy cycles.
    task automatic do_access(input int cs, input bit we, input int addr, input int wd);
        int w   = cfgs[cs];
        int rdw = w & 15, wrw = (w >> 4) & 15, hd = (w >> 8) & 15, rc = (w >> 12) & 15;
        int rdd = (w >> 16) & 255, wrd = (w >> 24) & 255;
        int page = (addr >> 4) & 31;
        bit first = !m_seen || cs != m_cs || page != m_page;
        bit rec_on = m_lastrd && (cs != m_cs || we);
        int e_rec = rec_on ? ((rc == 0) ? 1 : rc) : 0;
        int e_acc = (we ? wrw : rdw) + 1 + (first ? (we ? wrd : rdd) : 0);
        int e_hold = we ? hd + 1 : 0;
        int n_idle = 0, n_acc = 0, n_hold = 0, n_busy = 0, n_bad = 0;
        m_seen = 1; m_lastrd = !we; m_cs = cs; m_page = page;
        while (!host_ready) @(negedge clk);
        host_req = 1'b1; host_we = we; host_cs = 3'(cs);
        host_addr = 9'(addr); host_wdata = 16'(wd);
        @(negedge clk);
        host_req = 1'b0;
        while (!host_ready) begin
            n_busy++;
            if (&mem_cs_n) begin
                n_idle++;
                if (!mem_oe_n || !mem_we_n || n_acc != 0) n_bad++;
            end else begin
                if (mem_cs_n != ~(6'b1 << cs) || mem_addr != 9'(addr)) n_bad++;
                if (!we && (!mem_oe_n)) n_acc++;
                else if (we && !mem_we_n) begin
                    n_acc++;
                    if (!mem_dq_oe || mem_dq_o != 16'(wd)) n_bad++;
                end else begin
                    n_hold++;
                    if (!we || !mem_dq_oe || mem_dq_o != 16'(wd)) n_bad++;
                end
            end
            @(negedge clk);
        end
        check(n_idle == e_rec, rec_on ? "R6 recovery cycles" : "R7 no recovery", n_idle, e_rec);
        check(n_acc == e_acc, first ? "R5 first-access strobe length" :
              (we ? "R3 write strobe length" : "R2 read strobe length"), n_acc, e_acc);
        check(n_hold == e_hold, "R4 write hold cycles", n_hold, e_hold);
        check(n_busy == e_rec + e_acc + e_hold, "R8 ready low span", n_busy, e_rec + e_acc + e_hold);
        check(n_bad == 0, "R10 bus pin values during access", n_bad, 0);
        if (we) begin
            check(!host_rvalid, "R3 no rvalid after write", int'(host_rvalid), 0);
        end else begin
            check(host_rvalid, "R2 rvalid pulse", int'(host_rvalid), 1);
            check(host_rdata == {7'h35, 9'(addr)}, "R2 read data", int'(host_rdata),
                  int'({7'h35, 9'(addr)}));
            @(negedge clk);
            check(!host_rvalid, "R2 rvalid one cycle", int'(host_rvalid), 0);
        end
    endtask

    // Watchdog: a hung run counts as a failure and still reports.
    always @(posedge clk) begin
        cyc++;
        if (cyc > WATCHDOG) begin
            errors++;
            checks++;
            $display("FAIL watchdog expired after %0d cycles", cyc);
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        for (int i = 0; i < 6; i++) cfgs[i] = 0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check(host_ready && (&mem_cs_n) && mem_oe_n && mem_we_n && !mem_dq_oe,
              "R1 reset outputs", int'({host_ready, mem_oe_n, mem_we_n, mem_dq_oe}), 14);
        // R1: zero timing gives 1-cycle read with first-access delta 0.
        do_access(2, 1'b0, 9'h013, 0);
        do_access(2, 1'b1, 9'h013, 16'h1234);

        // R9: per-chip-select words differ; sweep configurations and patterns.
        for (int c = 0; c < 8; c++) begin
            for (int cs = 0; cs < 6; cs++) begin
                write_cfg(cs, pack((c + cs) % 4, (c * 3 + cs) % 4, (c + 2 * cs) % 3,
                                   (c + cs) % 3, ((c + cs) % 2) * 3, 2 * (cs % 2) + (c % 2)));
            end
            for (int k = 0; k < 24; k++) begin
                int cs  = ((k / 3) * 5 + c) % 6;
                bit we  = (k % 3 == 1) || (k % 5 == 0);
                int adr = (((k / 2) % 3) << 4) | ((k * 7) % 16);
                do_access(cs, we, adr, (k * 16'h0531) ^ (c << 12));
            end
        end

        // R9: rewriting cs1 must not alter cs0 timing.
        write_cfg(0, pack(2, 1, 1, 2, 0, 0));
        write_cfg(1, pack(15, 15, 15, 15, 255, 255));
        do_access(0, 1'b0, 9'h100, 0);
        do_access(0, 1'b1, 9'h100, 16'hBEEF);

        // Limits: largest wait, delta, recovery and hold.
        write_cfg(5, pack(15, 15, 15, 15, 255, 255));
        do_access(5, 1'b0, 9'h1F0, 0);
        do_access(5, 1'b0, 9'h1F5, 0);
        do_access(5, 1'b1, 9'h1F5, 16'hA5A5);
        do_access(5, 1'b1, 9'h0F5, 16'h5A5A);
        do_access(5, 1'b0, 9'h0F5, 0);
        do_access(1, 1'b0, 9'h0F5, 0);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule